// File: doc/BRIEF.md
# DMA Channel Address and Block Counter

This block keeps the address and count state of one DMA channel. A start pulse captures the channel settings: the source and destination start addresses, a transfer-width code per side, a step mode per side, the block size, the flow-control owner, and a reload flag per side. Once running, each source beat pulse moves the source address by one item and adds one to the count of items read. Each destination beat pulse moves the destination address in the same way.

The block ends in one of two ways. Under DMA flow control it ends on the source beat that brings the count up to the block size. Under peripheral flow control it ends when the last-request input is seen. At the block end a one-cycle done pulse is raised. A side with reload set returns to its captured start address. If either side reloads, the channel stays active and starts a new block; otherwise it goes idle.

Bus signalling, data storage and the request handshake belong to other blocks. Beat pulses and the last request arrive as plain single-cycle inputs.

Top module: `dma_chan_addr_ctr`

## Requirements
- R1: After a synchronous reset, both addresses and the item count are zero, and `busy`, `blk_done` and `align_err` are low.
- R2: A `start` pulse with both addresses aligned captures all `cfg_*` inputs, loads both addresses, clears the count and sets `busy`, all at the next edge. Later changes to `cfg_*` have no effect until the next start.
- R3: While busy, each `src_beat` changes the source address by 2^w bytes, where w is the 3-bit width code. Mode 00 adds the step, mode 01 subtracts it, and modes 10 and 11 leave the address unchanged. Arithmetic wraps modulo 2^32.
- R4: While busy, each `dst_beat` changes the destination address by the same rule as R3, using the destination width and mode.
- R5: Beats and `last_req` received while not busy change no output.
- R6: While busy, each `src_beat` adds one to `item_count`.
- R7: Under DMA flow control (`cfg_periph_fc`=0), the source beat that brings the count up to the block size ends the block. `blk_done` is high in the cycle after each block end.
- R8: Under peripheral flow control (`cfg_periph_fc`=1), `last_req` ends the block, and `item_count` saturates at 0xFFF.
- R9: At a block end, a side whose reload flag is set returns to its start address, while the other side keeps its stepped address. If any reload flag is set, `busy` stays high and the count restarts at 0. Otherwise `busy` falls and the count holds its final value.
- R10: A start whose source or destination address is not a multiple of its 2^w step sets `align_err`, clears `busy` and leaves the addresses unchanged. The next aligned start clears `align_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the configuration and begin a block |
| cfg_src_addr | input | 32 | Source start address |
| cfg_dst_addr | input | 32 | Destination start address |
| cfg_src_width | input | 3 | Source width code (step = 2^code bytes) |
| cfg_dst_width | input | 3 | Destination width code |
| cfg_src_mode | input | 2 | Source step mode (00 up, 01 down, 1x hold) |
| cfg_dst_mode | input | 2 | Destination step mode |
| cfg_blk_size | input | 12 | Items per block under DMA flow control |
| cfg_periph_fc | input | 1 | 1 = a peripheral owns flow control |
| cfg_src_reload | input | 1 | Reload the source address at each block end |
| cfg_dst_reload | input | 1 | Reload the destination address at each block end |
| src_beat | input | 1 | One source item transferred |
| dst_beat | input | 1 | One destination item transferred |
| last_req | input | 1 | Peripheral marks the block end |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| item_count | output | 12 | Source items read in this block |
| blk_done | output | 1 | One-cycle block-end pulse |
| busy | output | 1 | Channel active |
| align_err | output | 1 | Last start was rejected for misalignment |

## Verification
The bench goes after several corner cases, each of which a faulty design would get visibly wrong:
- Address wrap past 0xFFFFFFFF and below zero, where a design with a narrow adder or an unsigned compare would produce a wrong address.
- Hold mode at wide widths, where a design that decoded only one mode bit would step the address.
- A 4100-beat block under peripheral flow control, where a counter without saturation would wrap to a small count.
- Reload on one side only, where shared reload logic would snap both addresses back.
- A one-item block, which exposes a count compared one beat early or one beat late.
- Misaligned starts, where a design would either load anyway or stay busy.
- Beats received while idle, which a design would wrongly apply to the addresses.

// File: rtl/dma_ac_pkg.sv
package dma_ac_pkg;
  localparam int ADDR_W  = 32;
  localparam int WCODE_W = 3;
  localparam int CNT_W   = 12;

  typedef enum logic [1:0] {
    STEP_UP   = 2'b00,
    STEP_DOWN = 2'b01,
    STEP_HOLD = 2'b10
  } step_mode_e;

  function automatic logic [ADDR_W-1:0] step_bytes(input logic [WCODE_W-1:0] w);
    return ADDR_W'(1) << w;
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [WCODE_W-1:0] w,
                                                  input logic [1:0] m);
    logic [ADDR_W-1:0] r;
    r = a;
    if (m == STEP_UP)        r = a + step_bytes(w);
    else if (m == STEP_DOWN) r = a - step_bytes(w);
    return r;
  endfunction

  function automatic logic is_aligned(input logic [ADDR_W-1:0] a,
                                      input logic [WCODE_W-1:0] w);
    return (a & (step_bytes(w) - ADDR_W'(1))) == '0;
  endfunction
endpackage

// File: rtl/dma_ac_addr_gen.sv
module dma_ac_addr_gen
  import dma_ac_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic [WCODE_W-1:0] load_width,
  input  logic [1:0]         load_mode,
  input  logic               load_reload,
  input  logic               beat,
  input  logic               blk_end,
  output logic [ADDR_W-1:0]  addr,
  output logic               reload_q
);
  logic [ADDR_W-1:0]  base_q;
  logic [WCODE_W-1:0] width_q;
  logic [1:0]         mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      base_q   <= '0;
      width_q  <= '0;
      mode_q   <= '0;
      reload_q <= 1'b0;
    end else if (load) begin
      addr     <= load_addr;
      base_q   <= load_addr;
      width_q  <= load_width;
      mode_q   <= load_mode;
      reload_q <= load_reload;
    end else if (blk_end && reload_q) begin
      addr <= base_q;
    end else if (beat) begin
      addr <= next_addr(addr, width_q, mode_q);
    end
  end

  // R3 / R4: upward step by the width-derived byte count
  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (beat && !load && !(blk_end && reload_q) && mode_q == 2'b00)
      |=> addr == $past(addr) + (ADDR_W'(1) << $past(width_q)));

  // R3 / R4: hold modes leave the address alone
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !(blk_end && reload_q) && mode_q[1]) |=> $stable(addr));

  // R9: reload returns to the captured start address
  a_r9_reload: assert property (@(posedge clk) disable iff (rst)
    (blk_end && reload_q && !load) |=> addr == $past(base_q));
endmodule

// File: rtl/dma_ac_blk_ctr.sv
module dma_ac_blk_ctr
  import dma_ac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_size,
  input  logic             load_pfc,
  input  logic             beat,
  input  logic             last,
  input  logic             cont,
  output logic [CNT_W-1:0] count,
  output logic             blk_end
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] size_q;
  logic             pfc_q;
  logic [CNT_W-1:0] count_inc;

  assign count_inc = count + CNT_W'(1);

  always_comb begin
    if (pfc_q) blk_end = last;
    else       blk_end = beat && (count_inc == size_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      size_q <= '0;
      pfc_q  <= 1'b0;
    end else if (load) begin
      count  <= '0;
      size_q <= load_size;
      pfc_q  <= load_pfc;
    end else if (blk_end && cont) begin
      count <= '0;
    end else if (beat && !(pfc_q && count == CNT_MAX)) begin
      count <= count_inc;
    end
  end

  // R8: saturation under peripheral flow control
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (pfc_q && count == CNT_MAX && !load && !(blk_end && cont)) |=> count == CNT_MAX);

  // R6: the count never jumps by more than one item
  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count == '0 || count == $past(count) || count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/dma_chan_addr_ctr.sv
module dma_chan_addr_ctr
  import dma_ac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] cfg_src_addr,
  input  logic [31:0] cfg_dst_addr,
  input  logic [2:0]  cfg_src_width,
  input  logic [2:0]  cfg_dst_width,
  input  logic [1:0]  cfg_src_mode,
  input  logic [1:0]  cfg_dst_mode,
  input  logic [11:0] cfg_blk_size,
  input  logic        cfg_periph_fc,
  input  logic        cfg_src_reload,
  input  logic        cfg_dst_reload,
  input  logic        src_beat,
  input  logic        dst_beat,
  input  logic        last_req,
  output logic [31:0] src_addr,
  output logic [31:0] dst_addr,
  output logic [11:0] item_count,
  output logic        blk_done,
  output logic        busy,
  output logic        align_err
);
  logic aligned, load_ok, active;
  logic sb, db, lr, blk_end;
  logic src_rl, dst_rl, cont;

  assign aligned = is_aligned(cfg_src_addr, cfg_src_width) &&
                   is_aligned(cfg_dst_addr, cfg_dst_width);
  assign load_ok = start && aligned;
  assign active  = busy && !start;
  assign sb      = src_beat && active;
  assign db      = dst_beat && active;
  assign lr      = last_req && active;
  assign cont    = src_rl || dst_rl;

  dma_ac_addr_gen u_src (
    .clk(clk), .rst(rst), .load(load_ok), .load_addr(cfg_src_addr),
    .load_width(cfg_src_width), .load_mode(cfg_src_mode),
    .load_reload(cfg_src_reload), .beat(sb), .blk_end(blk_end),
    .addr(src_addr), .reload_q(src_rl));

  dma_ac_addr_gen u_dst (
    .clk(clk), .rst(rst), .load(load_ok), .load_addr(cfg_dst_addr),
    .load_width(cfg_dst_width), .load_mode(cfg_dst_mode),
    .load_reload(cfg_dst_reload), .beat(db), .blk_end(blk_end),
    .addr(dst_addr), .reload_q(dst_rl));

  dma_ac_blk_ctr u_ctr (
    .clk(clk), .rst(rst), .load(load_ok), .load_size(cfg_blk_size),
    .load_pfc(cfg_periph_fc), .beat(sb), .last(lr), .cont(cont),
    .count(item_count), .blk_end(blk_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      blk_done  <= 1'b0;
      align_err <= 1'b0;
    end else begin
      blk_done <= blk_end;
      if (start) begin
        align_err <= !aligned;
        busy      <= aligned;
      end else if (blk_end && !cont) begin
        busy <= 1'b0;
      end
    end
  end

  // R7: every block end is followed by the done pulse
  a_r7_done_after_end: assert property (@(posedge clk) disable iff (rst)
    blk_end |=> blk_done);

  // R5: idle channel ignores beats
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(src_addr) && $stable(dst_addr) && !blk_done));

  // R10: misaligned start is rejected
  a_r10_reject: assert property (@(posedge clk) disable iff (rst)
    (start && !aligned) |=> (align_err && !busy && $stable(src_addr) && $stable(dst_addr)));
endmodule

// File: tb/dma_chan_addr_ctr_tb_top.sv
module dma_chan_addr_ctr_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0;
  logic [31:0] cfg_src_addr = 0, cfg_dst_addr = 0;
  logic [2:0]  cfg_src_width = 0, cfg_dst_width = 0;
  logic [1:0]  cfg_src_mode = 0, cfg_dst_mode = 0;
  logic [11:0] cfg_blk_size = 0;
  logic cfg_periph_fc = 0, cfg_src_reload = 0, cfg_dst_reload = 0;
  logic src_beat = 0, dst_beat = 0, last_req = 0;
  logic [31:0] src_addr, dst_addr;
  logic [11:0] item_count;
  logic blk_done, busy, align_err;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_src = 0, m_dst = 0, m_sbase = 0, m_dbase = 0;
  logic [2:0]  m_sw = 0, m_dw = 0;
  logic [1:0]  m_sm = 0, m_dm = 0;
  logic        m_sr = 0, m_dr = 0, m_pfc = 0;
  logic [11:0] m_bs = 0, m_cnt = 0;
  logic        m_busy = 0, m_done = 0, m_err = 0;

  always #2 clk = ~clk;

  dma_chan_addr_ctr dut_i (.*);

  function automatic logic [31:0] mstep(logic [31:0] a, logic [2:0] w, logic [1:0] m);
    if (m == 2'b00) return a + (32'd1 << w);
    if (m == 2'b01) return a - (32'd1 << w);
    return a;
  endfunction

  function automatic logic misal(logic [31:0] a, logic [2:0] w);
    return (a & ((32'd1 << w) - 32'd1)) != 0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic ends;
    logic [11:0] nc;
    m_done = 0;
    if (rst) begin
      m_src = 0; m_dst = 0; m_sbase = 0; m_dbase = 0; m_sw = 0; m_dw = 0;
      m_sm = 0; m_dm = 0; m_sr = 0; m_dr = 0; m_pfc = 0; m_bs = 0; m_cnt = 0;
      m_busy = 0; m_err = 0;
    end else if (start) begin
      if (misal(cfg_src_addr, cfg_src_width) || misal(cfg_dst_addr, cfg_dst_width)) begin
        m_err = 1; m_busy = 0;
      end else begin
        m_err = 0; m_busy = 1; m_cnt = 0;
        m_src = cfg_src_addr; m_sbase = cfg_src_addr; m_dst = cfg_dst_addr; m_dbase = cfg_dst_addr;
        m_sw = cfg_src_width; m_dw = cfg_dst_width; m_sm = cfg_src_mode; m_dm = cfg_dst_mode;
        m_sr = cfg_src_reload; m_dr = cfg_dst_reload; m_pfc = cfg_periph_fc; m_bs = cfg_blk_size;
      end
    end else if (m_busy) begin
      ends = m_pfc ? last_req : (src_beat && 12'(m_cnt + 12'd1) == m_bs);
      nc = m_cnt;
      if (src_beat && !(m_pfc && m_cnt == 12'hFFF)) nc = m_cnt + 12'd1;
      if (src_beat) m_src = mstep(m_src, m_sw, m_sm);
      if (dst_beat) m_dst = mstep(m_dst, m_dw, m_dm);
      if (ends) begin
        m_done = 1;
        if (m_sr) m_src = m_sbase;
        if (m_dr) m_dst = m_dbase;
        if (m_sr || m_dr) m_cnt = 0;
        else begin m_cnt = nc; m_busy = 0; end
      end else m_cnt = nc;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    chk("R3", "src_addr", src_addr, m_src);
    chk("R4", "dst_addr", dst_addr, m_dst);
    chk("R6", "item_count", {20'd0, item_count}, {20'd0, m_cnt});
    chk("R7", "blk_done", {31'd0, blk_done}, {31'd0, m_done});
    chk("R2", "busy", {31'd0, busy}, {31'd0, m_busy});
    chk("R10", "align_err", {31'd0, align_err}, {31'd0, m_err});
  endtask

  task automatic cfg(logic [31:0] sa, logic [31:0] da, logic [2:0] sw, logic [2:0] dw,
                     logic [1:0] sm, logic [1:0] dm, logic [11:0] bs, logic pfc,
                     logic sr, logic dr);
    cfg_src_addr = sa; cfg_dst_addr = da; cfg_src_width = sw; cfg_dst_width = dw;
    cfg_src_mode = sm; cfg_dst_mode = dm; cfg_blk_size = bs; cfg_periph_fc = pfc;
    cfg_src_reload = sr; cfg_dst_reload = dr;
  endtask

  task automatic do_start();
    start = 1; tick(); start = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd7041);
    rst = 1;
    repeat (3) tick();
    rst = 0;
    // R1: reset state
    chk("R1", "src_addr", src_addr, 0);
    chk("R1", "count", {20'd0, item_count}, 0);
    chk("R1", "busy", {31'd0, busy}, 0);

    // R5: beats while idle are ignored
    src_beat = 1; dst_beat = 1; last_req = 1;
    repeat (3) tick();
    src_beat = 0; dst_beat = 0; last_req = 0;
    chk("R5", "idle src_addr", src_addr, 0);
    chk("R5", "idle blk_done", {31'd0, blk_done}, 0);

    // R3/R4 wrap, R2 config captured
    cfg(32'hFFFF_FFFC, 32'h0000_0004, 3'd2, 3'd2, 2'b00, 2'b01, 12'd100, 0, 0, 0);
    do_start();
    cfg_src_mode = 2'b11; cfg_src_width = 3'd6;
    src_beat = 1; dst_beat = 1; tick();
    src_beat = 0; tick();
    dst_beat = 0; tick();
    chk("R3", "wrap up", src_addr, 32'h0);
    chk("R4", "wrap down", dst_addr, 32'hFFFF_FFFC);
    chk("R2", "captured mode", {20'd0, item_count}, 32'd1);

    // R9 reload on source side only, R7 block of three
    cfg(32'h100, 32'h200, 3'd1, 3'd0, 2'b00, 2'b00, 12'd3, 0, 1, 0);
    do_start();
    src_beat = 1; dst_beat = 1;
    repeat (3) tick();
    src_beat = 0; dst_beat = 0;
    chk("R9", "src reloaded", src_addr, 32'h100);
    chk("R9", "dst kept", dst_addr, 32'h203);
    chk("R9", "still busy", {31'd0, busy}, 1);
    chk("R7", "done pulse", {31'd0, blk_done}, 1);
    tick();

    // R7 one-item block, no reload: busy drops
    cfg(32'h40, 32'h80, 3'd3, 3'd3, 2'b01, 2'b10, 12'd1, 0, 0, 0);
    do_start();
    src_beat = 1; tick(); src_beat = 0;
    chk("R7", "one item done", {31'd0, blk_done}, 1);
    chk("R9", "idle after", {31'd0, busy}, 0);
    chk("R7", "final count", {20'd0, item_count}, 1);
    tick();

    // R8 saturation under peripheral flow control
    cfg(32'h0, 32'h0, 3'd7, 3'd7, 2'b10, 2'b11, 12'd5, 1, 0, 0);
    do_start();
    src_beat = 1;
    repeat (4100) tick();
    src_beat = 0;
    chk("R8", "saturated", {20'd0, item_count}, 32'hFFF);
    chk("R8", "hold mode wide", src_addr, 32'h0);
    last_req = 1; tick(); last_req = 0;
    chk("R8", "last ends", {31'd0, blk_done}, 1);

    // R10 misaligned start
    cfg(32'h102, 32'h0, 3'd2, 3'd0, 2'b00, 2'b00, 12'd4, 0, 0, 0);
    do_start();
    chk("R10", "err set", {31'd0, align_err}, 1);
    chk("R10", "not busy", {31'd0, busy}, 0);
    cfg(32'h104, 32'h0, 3'd2, 3'd0, 2'b00, 2'b00, 12'd4, 0, 0, 0);
    do_start();
    chk("R10", "err cleared", {31'd0, align_err}, 0);

    // random sessions
    for (int s = 0; s < 250; s++) begin
      logic [2:0] sw, dw;
      logic [31:0] sa, da;
      logic pfc;
      sw = 3'($urandom % 8); dw = 3'($urandom % 8);
      sa = $urandom & ~((32'd1 << sw) - 1);
      da = $urandom & ~((32'd1 << dw) - 1);
      if ($urandom % 8 == 0) sa = sa | 32'd1;
      pfc = ($urandom % 3 == 0);
      cfg(sa, da, sw, dw, 2'($urandom), 2'($urandom), 12'(1 + $urandom % 12), pfc,
          1'($urandom), 1'($urandom));
      do_start();
      for (int k = 0; k < 40; k++) begin
        src_beat = 1'($urandom);
        dst_beat = 1'($urandom);
        last_req = ($urandom % 10 == 0);
        start = ($urandom % 60 == 0);
        tick();
      end
      src_beat = 0; dst_beat = 0; last_req = 0; start = 0;
    end
    summary();
  end
endmodule